// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an 8-bit general-purpose I/O port from a simple register bus. Three registers set how the port behaves. A data latch holds the values the pins drive. A direction register chooses, for each pin, whether it drives its latch value or acts as a high-impedance input. A write-only inhibit register turns off the pulldown of any chosen input pin. For every pin the block produces an output value, an output enable and a pulldown enable, which go to the pad ring.

Pin levels pass through a two-flop synchronizer. The synchronized levels feed the data-register read path. The low four of them also go out on an interrupt-request bus for a separate interrupt unit. A data read is mixed per pin: a pin set as output returns its latch bit, and a pin set as input returns its synchronized pad level. A static mask-option input, when high, keeps every pulldown off, including the state straight after reset.

The block has no state machine. Its only sequential elements are the three registers and the synchronizer stages, and every output is a direct function of those and of the address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is active, and directly after it, the direction register and the data latch are zero. So `pin_oe` = 0x00, `pin_out` = 0x00, and a read of offset 0x04 returns 0x00.
- R2: `pin_oe[i]` equals direction bit i, where 1 means the pin is an output and 0 means it is a high-impedance input.
- R3: `pin_out` always equals the data latch, whatever the direction bits are.
- R4: A read of offset 0x00 returns, for each bit i, the latch bit when direction bit i is 1 and the synchronized pin level when it is 0.
- R5: A write to offset 0x00 updates every latch bit, including the bits of input pins. For an input pin the read value does not change, and the written value appears once the pin is switched to output.
- R6: The inhibit register sits at offset 0x10, is written there, and always reads back as 0x00.
- R7: `pin_pd_en[i]` is 1 exactly when direction bit i is 0, inhibit bit i is 0 and the mask option is 0. An output pin never has its pulldown enabled.
- R8: While `mask_pd_off` is 1, `pin_pd_en` is 0x00, including directly after reset, when all pins are inputs.
- R9: `irq_pins` carries synchronized pin levels 3..0. A change at `pin_in` shows there after the second rising clock edge.
- R10: A change at an input pin shows up in a read of offset 0x00 after the second rising clock edge, and not after the first.
- R11: The direction register sits at offset 0x04. A write there takes effect on the edge where `wr_en` is high, and a read there returns the stored value.
- R12: Writes to any offset other than 0x00, 0x04 and 0x10 change no register. Reads of such offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_pd_off | input | 1 | Static option; 1 forces all pulldowns off |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pd_en | output | 8 | Pad pulldown enables |
| irq_pins | output | 4 | Synchronized levels of pins 3..0 |

## Verification
A corrupted direction bit shows at once on `pin_oe` and `pin_pd_en`. It also shows in the very next read of offset 0x00, which then returns the latch bit where the pad level was expected, or the other way round. A wrong latch bit shows on `pin_out` in the cycle after the write. A wrong inhibit bit shows only on `pin_pd_en`, because the register reads back as zero. A synchronizer that is off by one stage shows as a read or IRQ value one edge early or late, so the bench samples both after the first edge and after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W_DEF = 8;
    localparam int IRQ_W_DEF  = 4;
    localparam int ADDR_W_DEF = 5;
    localparam int SYNC_STAGES_DEF = 2;

    // Register byte offsets
    localparam int OFS_DATA = 'h00;
    localparam int OFS_DIR  = 'h04;
    localparam int OFS_INH  = 'h10;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_INH  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];
    logic         seen_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= d;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_edge <= 1'b0;
        end else begin
            seen_edge <= 1'b1;
        end
    end

    AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> (stg[0] == $past(d))); // R10

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = PORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] lat_q,
    output logic [PORT_W-1:0] inh_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lat_q <= '0;
            inh_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA: lat_q <= wr_data;
                SEL_DIR:  dir_q <= wr_data;
                SEL_INH:  inh_q <= wr_data;
                SEL_NONE: ;
            endcase
        end
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIR) |=> (dir_q == $past(wr_data))); // R11
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DATA) |=> (lat_q == $past(wr_data))); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_DATA) |=> $stable(lat_q)); // R12

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_pd_off,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] lat_q,
    input  logic [PORT_W-1:0] inh_q,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pd_en
);

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            assign pin_out[i]   = lat_q[i];
            assign pin_oe[i]    = dir_q[i];
            assign pin_pd_en[i] = !dir_q[i] && !inh_q[i] && !mask_pd_off;
        end
    endgenerate

    AST_PD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask_pd_off |-> (pin_pd_en == '0)); // R8
    AST_PD_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pd_en & pin_oe) == '0)); // R7

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PORT_W      = PORT_W_DEF,
    parameter int IRQ_W       = IRQ_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_pd_off,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pd_en,
    output logic [IRQ_W-1:0]  irq_pins
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_INH  = ADDR_W'(OFS_INH);

    reg_sel_e          sel;
    logic [PORT_W-1:0] dir_q, lat_q, inh_q, pin_sync;

    always_comb begin
        if (addr == A_DATA)      sel = SEL_DATA;
        else if (addr == A_DIR)  sel = SEL_DIR;
        else if (addr == A_INH)  sel = SEL_INH;
        else                     sel = SEL_NONE;
    end

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .inh_q   (inh_q)
    );

    gpio_pad_ctrl #(.PORT_W(PORT_W)) u_pad (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_pd_off (mask_pd_off),
        .dir_q       (dir_q),
        .lat_q       (lat_q),
        .inh_q       (inh_q),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pd_en   (pin_pd_en)
    );

    // Read mux: output pins return the latch, input pins the pad
    always_comb begin
        unique case (sel)
            SEL_DATA: rd_data = (dir_q & lat_q) | (~dir_q & pin_sync);
            SEL_DIR:  rd_data = dir_q;
            SEL_INH:  rd_data = '0;
            SEL_NONE: rd_data = '0;
        endcase
    end

    assign irq_pins = pin_sync[IRQ_W-1:0];

    AST_INH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_INH) |-> (rd_data == '0)); // R6
    AST_OUT_PIN_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_DATA) |-> ((rd_data & pin_oe) == (pin_out & pin_oe))); // R4
    AST_IRQ_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_DATA) |-> ((rd_data[IRQ_W-1:0] & ~pin_oe[IRQ_W-1:0]) ==
                              (irq_pins & ~pin_oe[IRQ_W-1:0]))); // R9

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_pd_off = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pd_en;
    logic [3:0] irq_pins;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mask_pd_off(mask_pd_off), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pd_en(pin_pd_en),
        .irq_pins(irq_pins)
    );

    // {dir, latch, pin, expected data read}
    localparam logic [31:0] VEC [8] = '{
        32'hFF_A5_00_A5,
        32'h00_A5_3C_3C,
        32'hF0_5A_0F_5F,
        32'h0F_33_CC_C3,
        32'hAA_FF_00_AA,
        32'h55_00_FF_AA,
        32'h81_81_7E_FF,
        32'h3C_C3_81_81
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 5'h1F;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        pin_in = 8'h5A;
        repeat (3) @(negedge clk);
        // R1: reset state, during reset
        check("R1 oe in reset", pin_oe, 8'h00);
        check("R1 out in reset", pin_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h04, v); check("R1 dir after reset", v, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);
        check("R7 pd all inputs", pin_pd_en, 8'hFF);

        // Table walk: R2 R3 R4 R7 R11
        for (int k = 0; k < 8; k++) begin
            wr(5'h04, VEC[k][31:24]);
            wr(5'h00, VEC[k][23:16]);
            pin_in = VEC[k][15:8];
            repeat (3) @(negedge clk);
            rd(5'h00, v); check("R4 mixed read", v, VEC[k][7:0]);
            rd(5'h04, v); check("R11 dir readback", v, VEC[k][31:24]);
            check("R2 oe", pin_oe, VEC[k][31:24]);
            check("R3 out", pin_out, VEC[k][23:16]);
            check("R7 pd", pin_pd_en, ~VEC[k][31:24]);
        end

        // R5: latch write on input pins
        wr(5'h04, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        wr(5'h00, 8'hC6);
        rd(5'h00, v); check("R5 input read unaffected", v, 8'h00);
        check("R5 latch on pin_out", pin_out, 8'hC6);
        wr(5'h04, 8'hFF);
        rd(5'h00, v); check("R5 latch after dir flip", v, 8'hC6);

        // R6: inhibit write-only, affects pulldowns
        wr(5'h04, 8'hF0);
        wr(5'h10, 8'h3C);
        rd(5'h10, v); check("R6 inh reads zero", v, 8'h00);
        check("R7 pd with inhibit", pin_pd_en, 8'h03);

        // R12: unmapped offsets
        wr(5'h08, 8'hAA);
        wr(5'h14, 8'h55);
        rd(5'h04, v); check("R12 dir untouched", v, 8'hF0);
        check("R12 latch untouched", pin_out, 8'hC6);
        check("R12 pd untouched", pin_pd_en, 8'h03);
        rd(5'h08, v); check("R12 unmapped read", v, 8'h00);

        // R9 R10: exact two-edge latency
        wr(5'h04, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h9B;
        @(negedge clk);
        rd(5'h00, v); check("R10 not after first edge", v, 8'h00);
        check("R9 irq not after first edge", {4'h0, irq_pins}, 8'h00);
        @(negedge clk);
        rd(5'h00, v); check("R10 after second edge", v, 8'h9B);
        check("R9 irq after second edge", {4'h0, irq_pins}, 8'h0B);

        // R8: mask option forces pulldowns off, also after reset
        mask_pd_off = 1'b1;
        do_reset();
        check("R8 pd off after reset", pin_pd_en, 8'h00);
        check("R1 dir inputs after reset", pin_oe, 8'h00);
        wr(5'h10, 8'h00);
        check("R8 pd off with inh clear", pin_pd_en, 8'h00);
        mask_pd_off = 1'b0;
        #1;
        check("R7 pd back when option low", pin_pd_en, 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule